// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Edge Interrupts

The controller drives general-purpose pins that are grouped into banks. All banks sit behind one synchronous register port. Each pin is set as an input or an output. Its input can be inverted by a polarity bit before it is read or edge-checked. Output latches change through whole-word writes or through write-one strobes that set, clear or invert chosen bits. A strobe never disturbs the bits written as zero.

Every pin input passes through a two-flop synchronizer. Rising-edge and falling-edge detection are enabled per pin and per direction. A detected edge latches a status bit and records whether the edge was rising or falling. Software clears status bits by writing ones to them. One interrupt line is raised while any status bit in any bank is set. The block's edge is the pin vectors and the register port. Pad drivers and pin multiplexing sit outside it.

Top module: `gpio_banks`

## Requirements
- R1: After reset, pinOut, pinOe, irq and rdData are all zero. Every configuration register reads zero.
- R2: Bit n of a bank's direction register (bank 0 offset 0x24) drives pinOe for pin n of that bank. A 1 means output, a 0 means input.
- R3: A write to the set register (bank 0 offset 0x2C) drives high each output latch whose data bit is 1. A write to the clear register (0x30) drives low each latch whose bit is 1. Latches whose bit is 0 keep their value.
- R4: A write to the invert register (0x34) flips each output latch whose bit is 1. A write to the data register (0x20) loads all latches of that bank directly.
- R5: A read of the data register returns each pin's synchronized input XOR its polarity bit (offset 0x28, 1 = invert). A pin change is visible after two clock edges.
- R6: A rising edge with the pin's rising enable set (0x08), or a falling edge with its falling enable set (0x0C), sets the pin's status bit (0x00). It also writes the pin's cause bit (0x04): 1 for rising, 0 for falling. An edge whose enable is 0 sets nothing.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it alone. An edge that arrives in the same cycle as the clearing write leaves the bit set.
- R8: irq is high exactly while at least one status bit in any bank is set.
- R9: Bank 0 uses offsets 0x00, 0x04, 0x08, 0x0C, 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 for status, cause, rising enable, falling enable, data, direction, polarity, set, clear and invert. Bank 1 holds the same ten registers in the same order at a 4-byte stride from 0x38, and bank 2 does the same from 0x60. A read with rdEn presents its word on rdData after the next clock edge.
- R10: Reads of the set, clear and invert offsets and of unmapped addresses return zero. A write to a register in one bank leaves the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | DATA_W | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W | Read data, registered |
| pinIn | input | NUM_BANKS*BANK_WIDTH | Pin input levels, bank 0 in the low bits |
| pinOut | output | NUM_BANKS*BANK_WIDTH | Output latch values |
| pinOe | output | NUM_BANKS*BANK_WIDTH | Output enables, taken from the direction bits |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: three banks of 32 pins, a 32-bit bus and an 8-bit address. At these values every pin of every bank is present, including the upper bits of the third bank. The whole map is decodable, up to the last invert offset at 0x84. Because banks are distinct, the bench can show that a register written in one bank does not leak into another. It can also show that edges in bank 0 and bank 2 keep the shared interrupt raised on their own.

// File: rtl/gpio_banks_pkg.sv
package gpio_banks_pkg;

  typedef enum logic [3:0] {
    RegStatus, RegCause, RegRiseEn, RegFallEn, RegLevel,
    RegDir, RegPol, RegSet, RegClr, RegTog
  } regSel_e;

  localparam int NUM_REGS   = 10;
  localparam int REG_STRIDE = 4;
  localparam int SPLIT_IDX  = 4;    // bank 0 jumps after its interrupt group
  localparam int SPLIT_BASE = 32;   // where bank 0's pin group starts
  localparam int BANK1_BASE = 56;   // first fully packed bank
  localparam int BANK_SPAN  = NUM_REGS * REG_STRIDE;

  function automatic int regOffset(input int bank, input int idx);
    if (bank == 0)
      return (idx < SPLIT_IDX) ? idx * REG_STRIDE
                               : SPLIT_BASE + (idx - SPLIT_IDX) * REG_STRIDE;
    return BANK1_BASE + (bank - 1) * BANK_SPAN + idx * REG_STRIDE;
  endfunction

  typedef struct packed {
    logic clrStatus;
    logic wrRise;
    logic wrFall;
    logic wrLatch;
    logic wrDir;
    logic wrPol;
    logic setOut;
    logic clrOut;
    logic togOut;
  } bankStrobe_t;

endpackage

// File: rtl/gpio_pinbank.sv
module gpio_pinbank
  import gpio_banks_pkg::*;
#(
  parameter int BANK_WIDTH = 32,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStrobe_t           stb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [BANK_WIDTH-1:0] pinIn,
  output logic [BANK_WIDTH-1:0] pinOut,
  output logic [BANK_WIDTH-1:0] pinOe,
  output logic [BANK_WIDTH-1:0] status,
  output logic [BANK_WIDTH-1:0] cause,
  output logic [BANK_WIDTH-1:0] riseEn,
  output logic [BANK_WIDTH-1:0] fallEn,
  output logic [BANK_WIDTH-1:0] level,
  output logic [BANK_WIDTH-1:0] pol
);

  logic [BANK_WIDTH-1:0] wrBits;
  logic [BANK_WIDTH-1:0] syncA, syncB, prevLevel;
  logic [BANK_WIDTH-1:0] outLatch, dirReg, polReg, riseReg, fallReg;
  logic [BANK_WIDTH-1:0] statusReg, causeReg;
  logic [BANK_WIDTH-1:0] rise, fall, hit;

  assign wrBits = wrData[BANK_WIDTH-1:0];
  assign level  = syncB ^ polReg;
  assign rise   = level & ~prevLevel;
  assign fall   = ~level & prevLevel;
  assign hit    = (rise & riseReg) | (fall & fallReg);

  // input path: two-flop synchronizer, then the edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      prevLevel <= '0;
    end else begin
      syncA     <= pinIn;
      syncB     <= syncA;
      prevLevel <= level;
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      polReg  <= '0;
      riseReg <= '0;
      fallReg <= '0;
    end else begin
      if (stb.wrDir)  dirReg  <= wrBits;
      if (stb.wrPol)  polReg  <= wrBits;
      if (stb.wrRise) riseReg <= wrBits;
      if (stb.wrFall) fallReg <= wrBits;
    end
  end

  // output latch with write-one modifiers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outLatch <= '0;
    else if (stb.wrLatch)  outLatch <= wrBits;
    else if (stb.setOut)   outLatch <= outLatch | wrBits;
    else if (stb.clrOut)   outLatch <= outLatch & ~wrBits;
    else if (stb.togOut)   outLatch <= outLatch ^ wrBits;
  end

  // interrupt status: new edges beat a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      causeReg  <= '0;
    end else begin
      statusReg <= (statusReg & ~(stb.clrStatus ? wrBits : '0)) | hit;
      causeReg  <= (causeReg & ~hit) | (rise & hit);
    end
  end

  assign pinOut = outLatch;
  assign pinOe  = dirReg;
  assign status = statusReg;
  assign cause  = causeReg;
  assign riseEn = riseReg;
  assign fallEn = fallReg;
  assign pol    = polReg;

  assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.setOut |=> ((outLatch & $past(wrBits)) == $past(wrBits)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrOut |=> ((outLatch & $past(wrBits)) == '0));

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.togOut |=> (outLatch == ($past(outLatch) ^ $past(wrBits))));

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|hit) |=> ((statusReg & $past(hit)) == $past(hit)));

  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!(|hit) && !stb.clrStatus) |=> $stable(statusReg));

endmodule

// File: rtl/gpio_regctl.sv
module gpio_regctl
  import gpio_banks_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_WIDTH = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            wrEn,
  input  logic                            rdEn,
  output logic [DATA_W-1:0]               rdData,
  output bankStrobe_t [NUM_BANKS-1:0]     strobes,
  input  logic [NUM_BANKS*BANK_WIDTH-1:0] status,
  input  logic [NUM_BANKS*BANK_WIDTH-1:0] cause,
  input  logic [NUM_BANKS*BANK_WIDTH-1:0] riseEn,
  input  logic [NUM_BANKS*BANK_WIDTH-1:0] fallEn,
  input  logic [NUM_BANKS*BANK_WIDTH-1:0] level,
  input  logic [NUM_BANKS*BANK_WIDTH-1:0] dir,
  input  logic [NUM_BANKS*BANK_WIDTH-1:0] pol
);

  localparam int STB_W = NUM_BANKS * $bits(bankStrobe_t);

  logic [DATA_W-1:0] rdNext;
  logic [STB_W-1:0]  flatStb;

  always_comb begin
    strobes = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wrEn && addr == ADDR_W'(regOffset(b, i))) begin
          case (regSel_e'(i))
            RegStatus: strobes[b].clrStatus = 1'b1;
            RegRiseEn: strobes[b].wrRise    = 1'b1;
            RegFallEn: strobes[b].wrFall    = 1'b1;
            RegLevel:  strobes[b].wrLatch   = 1'b1;
            RegDir:    strobes[b].wrDir     = 1'b1;
            RegPol:    strobes[b].wrPol     = 1'b1;
            RegSet:    strobes[b].setOut    = 1'b1;
            RegClr:    strobes[b].clrOut    = 1'b1;
            RegTog:    strobes[b].togOut    = 1'b1;
            default:   ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdNext = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (addr == ADDR_W'(regOffset(b, i))) begin
          case (regSel_e'(i))
            RegStatus: rdNext = DATA_W'(status[b*BANK_WIDTH +: BANK_WIDTH]);
            RegCause:  rdNext = DATA_W'(cause[b*BANK_WIDTH +: BANK_WIDTH]);
            RegRiseEn: rdNext = DATA_W'(riseEn[b*BANK_WIDTH +: BANK_WIDTH]);
            RegFallEn: rdNext = DATA_W'(fallEn[b*BANK_WIDTH +: BANK_WIDTH]);
            RegLevel:  rdNext = DATA_W'(level[b*BANK_WIDTH +: BANK_WIDTH]);
            RegDir:    rdNext = DATA_W'(dir[b*BANK_WIDTH +: BANK_WIDTH]);
            RegPol:    rdNext = DATA_W'(pol[b*BANK_WIDTH +: BANK_WIDTH]);
            default:   rdNext = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  assign flatStb = strobes;

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flatStb));

  assert_wo_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == ADDR_W'(regOffset(0, int'(RegSet))) ||
              addr == ADDR_W'(regOffset(0, int'(RegClr))) ||
              addr == ADDR_W'(regOffset(0, int'(RegTog)))))
    |=> (rdData == '0));

endmodule

// File: rtl/gpio_banks.sv
module gpio_banks
  import gpio_banks_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_WIDTH = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wrData,
  input  logic                            wrEn,
  input  logic                            rdEn,
  output logic [DATA_W-1:0]               rdData,
  input  logic [NUM_BANKS*BANK_WIDTH-1:0] pinIn,
  output logic [NUM_BANKS*BANK_WIDTH-1:0] pinOut,
  output logic [NUM_BANKS*BANK_WIDTH-1:0] pinOe,
  output logic                            irq
);

  localparam int PINS = NUM_BANKS * BANK_WIDTH;

  bankStrobe_t [NUM_BANKS-1:0] strobes;
  logic [PINS-1:0] statusAll, causeAll, riseAll, fallAll, levelAll, polAll;

  gpio_regctl #(
    .NUM_BANKS(NUM_BANKS), .BANK_WIDTH(BANK_WIDTH),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .strobes(strobes),
    .status(statusAll), .cause(causeAll), .riseEn(riseAll),
    .fallEn(fallAll), .level(levelAll), .dir(pinOe), .pol(polAll)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_pinbank #(.BANK_WIDTH(BANK_WIDTH), .DATA_W(DATA_W)) bank (
      .clk(clk), .rstN(rstN), .stb(strobes[b]), .wrData(wrData),
      .pinIn (pinIn[b*BANK_WIDTH +: BANK_WIDTH]),
      .pinOut(pinOut[b*BANK_WIDTH +: BANK_WIDTH]),
      .pinOe (pinOe[b*BANK_WIDTH +: BANK_WIDTH]),
      .status(statusAll[b*BANK_WIDTH +: BANK_WIDTH]),
      .cause (causeAll[b*BANK_WIDTH +: BANK_WIDTH]),
      .riseEn(riseAll[b*BANK_WIDTH +: BANK_WIDTH]),
      .fallEn(fallAll[b*BANK_WIDTH +: BANK_WIDTH]),
      .level (levelAll[b*BANK_WIDTH +: BANK_WIDTH]),
      .pol   (polAll[b*BANK_WIDTH +: BANK_WIDTH])
    );
  end

  assign irq = |statusAll;

endmodule

// File: tb/gpio_banks_test.sv
`timescale 1ns/1ps
module gpio_banks_test;

  localparam int NB = 3;
  localparam int BW = 32;
  localparam int PINS = NB * BW;
  localparam int NVEC = 12;

  // {isWrite, requirement, address, data-or-expected}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, 4'd9,  8'h08, 32'hA5A5_0001},  // R9 bank 0 rising enable
    {1'b1, 4'd9,  8'h0C, 32'h0000_00F0},  // R9 bank 0 falling enable
    {1'b1, 4'd9,  8'h40, 32'h1234_5678},  // R9 bank 1 rising enable
    {1'b1, 4'd9,  8'h74, 32'hCAFE_0000},  // R9 bank 2 direction
    {1'b0, 4'd9,  8'h08, 32'hA5A5_0001},
    {1'b0, 4'd9,  8'h0C, 32'h0000_00F0},
    {1'b0, 4'd9,  8'h40, 32'h1234_5678},
    {1'b0, 4'd9,  8'h74, 32'hCAFE_0000},
    {1'b0, 4'd10, 8'h2C, 32'h0000_0000},  // R10 set reads zero
    {1'b0, 4'd10, 8'h84, 32'h0000_0000},  // R10 bank 2 invert reads zero
    {1'b0, 4'd10, 8'h10, 32'h0000_0000},  // R10 unmapped gap
    {1'b0, 4'd10, 8'h44, 32'h0000_0000}   // R10 bank 1 falling untouched
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [31:0] rdData;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut, pinOe;
  logic irq;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  gpio_banks uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irq(irq)
  );

  task automatic check(input string req, input logic [PINS-1:0] act,
                       input logic [PINS-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 pinOut", pinOut, '0);
    check("R1 pinOe", pinOe, '0);
    check("R1 irq", {95'b0, irq}, '0);
    rd(8'h24, rv);
    check("R1 direction", {64'b0, rv}, '0);

    // R9 / R10 register map table
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][44]) wr(VEC[k][39:32], VEC[k][31:0]);
      else begin
        rd(VEC[k][39:32], rv);
        check($sformatf("R%0d table %0d", VEC[k][43:40], k),
              {64'b0, rv}, {64'b0, VEC[k][31:0]});
      end
    end

    doReset();
    check("R1 after second reset", pinOe, '0);

    // R2 direction drives output enables of one bank only
    wr(8'h4C, 32'hFF00_FF00);
    check("R2 pinOe", pinOe, {32'h0, 32'hFF00_FF00, 32'h0});

    // R3 set and clear leave zero bits alone
    wr(8'h2C, 32'h0000_000F);
    wr(8'h2C, 32'h0000_00F0);
    check("R3 set", pinOut, {64'h0, 32'h0000_00FF});
    wr(8'h30, 32'h0000_003C);
    check("R3 clear", pinOut, {64'h0, 32'h0000_00C3});

    // R4 invert and direct load
    wr(8'h34, 32'h0000_0101);
    check("R4 invert", pinOut, {64'h0, 32'h0000_01C2});
    wr(8'h70, 32'h0000_0055);
    check("R4 load bank 2", pinOut, {32'h55, 32'h0, 32'h0000_01C2});
    wr(8'h20, 32'hDEAD_BEEF);
    check("R4 load bank 0", pinOut, {32'h55, 32'h0, 32'hDEAD_BEEF});

    // R5 synchronized level with polarity
    @(negedge clk);
    pinIn[63:32] = 32'h0000_00AA;
    repeat (3) @(negedge clk);
    rd(8'h48, rv);
    check("R5 level", {64'b0, rv}, {64'b0, 32'h0000_00AA});
    wr(8'h50, 32'h0000_000F);
    rd(8'h48, rv);
    check("R5 inverted", {64'b0, rv}, {64'b0, 32'h0000_00A5});

    // R6 edge enables and cause in bank 2
    wr(8'h68, 32'h0000_0001);   // rising on pin 0
    wr(8'h6C, 32'h0000_0002);   // falling on pin 1
    @(negedge clk);
    pinIn[65:64] = 2'b11;
    repeat (4) @(negedge clk);
    rd(8'h60, rv);
    check("R6 rising status", {64'b0, rv}, {64'b0, 32'h1});
    rd(8'h64, rv);
    check("R6 rising cause", {64'b0, rv}, {64'b0, 32'h1});
    check("R8 irq set", {95'b0, irq}, {95'b0, 1'b1});
    wr(8'h60, 32'h0000_0001);
    rd(8'h60, rv);
    check("R7 clear", {64'b0, rv}, '0);
    check("R8 irq clear", {95'b0, irq}, '0);
    @(negedge clk);
    pinIn[65:64] = 2'b00;
    repeat (4) @(negedge clk);
    rd(8'h60, rv);
    check("R6 falling status", {64'b0, rv}, {64'b0, 32'h2});
    rd(8'h64, rv);
    check("R6 falling cause", {64'b0, rv}, {64'b0, 32'h1});

    // R8 irq held by bank 0 after bank 2 clears
    wr(8'h08, 32'h0000_0004);
    @(negedge clk);
    pinIn[2] = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h60, 32'h0000_0002);
    check("R8 irq from bank 0", {95'b0, irq}, {95'b0, 1'b1});
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, rv);
    check("R7 zero write keeps", {64'b0, rv}, {64'b0, 32'h4});

    // R7 new edge coincides with the clearing write
    @(negedge clk);
    pinIn[2] = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk);
    pinIn[2] = 1'b1;
    @(negedge clk);
    wr(8'h00, 32'h0000_0004);
    rd(8'h00, rv);
    check("R7 edge wins", {64'b0, rv}, {64'b0, 32'h4});
    wr(8'h00, 32'h0000_0004);
    rd(8'h00, rv);
    check("R7 clear later", {64'b0, rv}, '0);
    check("R8 irq low", {95'b0, irq}, '0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule